// File: doc/BRIEF.md
# Program Sequencer with Call Stack

This block is the program-flow controller of a small 8-bit processor whose instruction space is 10 bits wide. It holds the program counter, a circular return-address stack, the interrupt-enable flag and a pair of flag copies that are saved when an interrupt is taken. The decoder outside the block supplies the instruction class, the 3-bit condition field, the 10-bit target address and a one-bit selector. The ALU supplies the current ZERO and CARRY flags. The block returns the address of the next instruction to fetch. When a return-from-interrupt runs, it also returns the flag values that the ALU flag register must reload.

Every instruction takes two clocks, and the program counter moves only on the second clock edge. At that edge the block samples the level-sensitive interrupt input. If the enable flag, as the finished instruction left it, is set, a two-clock interrupt event follows. The acknowledge output is high during the second clock of that event. The event then stacks the address of the instruction it preempted, saves ZERO and CARRY, clears the enable and vectors to the all-ones address. A subroutine return resumes one past the stacked address. A return-from-interrupt resumes at the stacked address itself.

Top module: `prog_sequencer`

## Requirements
- R1: Each instruction takes two clocks. `pc_o` holds steady through the first clock and updates on the second clock edge. A sequential instruction (class 0) advances the PC by one, modulo 1024, so 0x3FF+1 gives 0x000.
- R2: The condition field decides whether jump, call and return are taken. `cond_i[2]`=0 means always. 100 means ZERO set, 101 means ZERO clear, 110 means CARRY set and 111 means CARRY clear. When the condition fails, the PC advances by one.
- R3: A taken JUMP (class 1) loads `target_i` and leaves the stack alone. A taken CALL (class 2) pushes the current PC and loads `target_i`.
- R4: A taken RETURN (class 3) pops the stack and loads the popped address plus one. It never drives flag restore, so `restore_o` stays low.
- R5: The stack holds 31 entries as a circular buffer. When a 32nd nested push overwrites the oldest entry, `stack_ovf_o` goes high and stays high until reset. Pops still return the most recent entries in reverse order.
- R6: At an instruction boundary, if the enable left by that instruction is 1 and `irq_i` is high, a two-clock interrupt event runs. `int_ack_o` is high only during its second clock. At the end of the event the preempted PC is pushed, `zero_i` and `carry_i` are saved, the enable is cleared and the PC becomes 0x3FF.
- R7: Return-from-interrupt (class 4) pops the stack into the PC without incrementing it. During its second clock, `restore_o` is high and `restore_zero_o`/`restore_carry_o` carry the saved flags. The enable becomes `sel_i`.
- R8: Interrupt control (class 5) sets the enable to `sel_i` and advances the PC by one.
- R9: Reset sets the PC to 0, clears the enable, empties the stack and clears `stack_ovf_o`. `int_ack_o` and `restore_o` are low during reset.
- R10: While the enable is 0, `irq_i` has no effect on the program flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| op_class_i | input | 3 | Instruction class: 0 seq, 1 jump, 2 call, 3 return, 4 return-from-interrupt, 5 interrupt control |
| cond_i | input | 3 | Condition field |
| target_i | input | 10 | Jump/call target address |
| sel_i | input | 1 | Enable value for classes 4 and 5 |
| zero_i | input | 1 | Current ZERO flag |
| carry_i | input | 1 | Current CARRY flag |
| irq_i | input | 1 | Level-sensitive interrupt request |
| pc_o | output | 10 | Program counter |
| int_ack_o | output | 1 | Interrupt acknowledge |
| int_en_o | output | 1 | Interrupt enable flag |
| restore_o | output | 1 | Flag restore strobe |
| restore_zero_o | output | 1 | ZERO value to restore |
| restore_carry_o | output | 1 | CARRY value to restore |
| stack_ovf_o | output | 1 | Sticky stack overflow |

## Verification
The hardest situation to reach is the wrap of the return stack. The stimulus gets there with a chain of 32 nested calls, each targeting two past its own address, so that the 32nd push lands on the oldest slot. A return is then issued, and the PC it produces shows whether the newest entry survived. The interrupt path is the other delicate area. The stimulus holds the request high across an instruction boundary, checks the acknowledge one clock into the event, and changes the flag inputs inside the service routine. This proves that the return-from-interrupt replays the saved values and not the live ones.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        OP_SEQ   = 3'd0,
        OP_JUMP  = 3'd1,
        OP_CALL  = 3'd2,
        OP_RET   = 3'd3,
        OP_RETI  = 3'd4,
        OP_IECTL = 3'd5
    } op_class_e;

    typedef enum logic [1:0] {
        ST_EXEC0 = 2'd0,
        ST_EXEC1 = 2'd1,
        ST_IRQ0  = 2'd2,
        ST_IRQ1  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval (
    input  logic [2:0] cond_i,
    input  logic       zero_i,
    input  logic       carry_i,
    output logic       pass_o
);
    always_comb begin
        if (!cond_i[2]) begin
            pass_o = 1'b1;
        end else begin
            case (cond_i[1:0])
                2'b00:   pass_o = zero_i;
                2'b01:   pass_o = !zero_i;
                2'b10:   pass_o = carry_i;
                default: pass_o = !carry_i;
            endcase
        end
    end
endmodule

// File: rtl/seq_call_stack.sv
module seq_call_stack #(
    parameter int AW    = 10,
    parameter int DEPTH = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] data_i,
    output logic [AW-1:0] top_o,
    output logic          ovf_o
);
    localparam int PW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] fill;
        logic          ovf;
    } stk_regs_t;

    stk_regs_t     stk_q, stk_d;
    logic [AW-1:0] mem_q [DEPTH];
    logic [PW-1:0] ptr_next, ptr_prev;

    always_comb begin
        ptr_next = (stk_q.ptr == PW'(DEPTH - 1)) ? '0 : stk_q.ptr + 1'b1;
        ptr_prev = (stk_q.ptr == '0) ? PW'(DEPTH - 1) : stk_q.ptr - 1'b1;
        top_o    = mem_q[ptr_prev];
        stk_d    = stk_q;
        if (push_i) begin
            stk_d.ptr = ptr_next;
            if (stk_q.fill == PW'(DEPTH)) begin
                stk_d.ovf = 1'b1;
            end else begin
                stk_d.fill = stk_q.fill + 1'b1;
            end
        end else if (pop_i) begin
            stk_d.ptr = ptr_prev;
            if (stk_q.fill != '0) begin
                stk_d.fill = stk_q.fill - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[stk_q.ptr] <= data_i;
        end
    end

    assign ovf_o = stk_q.ovf;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o); // R5
    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
        push_i |=> top_o == $past(data_i)); // R3
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import seq_pkg::*;
#(
    parameter int AW          = 10,
    parameter int STACK_DEPTH = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_class_i,
    input  logic [2:0]    cond_i,
    input  logic [AW-1:0] target_i,
    input  logic          sel_i,
    input  logic          zero_i,
    input  logic          carry_i,
    input  logic          irq_i,
    output logic [AW-1:0] pc_o,
    output logic          int_ack_o,
    output logic          int_en_o,
    output logic          restore_o,
    output logic          restore_zero_o,
    output logic          restore_carry_o,
    output logic          stack_ovf_o
);
    localparam logic [AW-1:0] IRQ_VECTOR = {AW{1'b1}};

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] pc;
        logic          ie;
        logic          sav_z;
        logic          sav_c;
    } regs_t;

    regs_t         r_q, r_d;
    op_class_e     op;
    logic          cond_ok;
    logic          push, pop;
    logic [AW-1:0] push_data, stack_top, pc_inc;

    seq_cond_eval u_cond (
        .cond_i  (cond_i),
        .zero_i  (zero_i),
        .carry_i (carry_i),
        .pass_o  (cond_ok)
    );

    seq_call_stack #(.AW(AW), .DEPTH(STACK_DEPTH)) u_stack (
        .clk    (clk),
        .rst    (rst),
        .push_i (push),
        .pop_i  (pop),
        .data_i (push_data),
        .top_o  (stack_top),
        .ovf_o  (stack_ovf_o)
    );

    always_comb begin
        op        = op_class_e'(op_class_i);
        pc_inc    = r_q.pc + 1'b1;
        r_d       = r_q;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = r_q.pc;
        case (r_q.state)
            ST_EXEC0: r_d.state = ST_EXEC1;
            ST_EXEC1: begin
                r_d.pc = pc_inc;
                case (op)
                    OP_JUMP: if (cond_ok) r_d.pc = target_i;
                    OP_CALL: if (cond_ok) begin
                        r_d.pc = target_i;
                        push   = 1'b1;
                    end
                    OP_RET: if (cond_ok) begin
                        r_d.pc = stack_top + 1'b1;
                        pop    = 1'b1;
                    end
                    OP_RETI: begin
                        r_d.pc = stack_top;
                        pop    = 1'b1;
                        r_d.ie = sel_i;
                    end
                    OP_IECTL: r_d.ie = sel_i;
                    default: ;
                endcase
                r_d.state = (r_d.ie && irq_i) ? ST_IRQ0 : ST_EXEC0;
            end
            ST_IRQ0: r_d.state = ST_IRQ1;
            default: begin
                push      = 1'b1;
                r_d.pc    = IRQ_VECTOR;
                r_d.ie    = 1'b0;
                r_d.sav_z = zero_i;
                r_d.sav_c = carry_i;
                r_d.state = ST_EXEC0;
            end
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            r_q <= '{state: ST_EXEC0, pc: '0, ie: 1'b0, sav_z: 1'b0, sav_c: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_o            = r_q.pc;
    assign int_en_o        = r_q.ie;
    assign int_ack_o       = (r_q.state == ST_IRQ1);
    assign restore_o       = (r_q.state == ST_EXEC1) && (op == OP_RETI);
    assign restore_zero_o  = r_q.sav_z;
    assign restore_carry_o = r_q.sav_c;

    AST_PC_HOLD_FIRST: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_EXEC0) |=> $stable(pc_o)); // R1
    AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (rst)
        int_ack_o |=> (pc_o == IRQ_VECTOR) && !int_en_o); // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        int_ack_o |=> !int_ack_o); // R6
    AST_CALL_STACKS_PC: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_EXEC1 && op == OP_CALL && cond_ok) |=> stack_top == $past(pc_o)); // R3
endmodule

// File: tb/prog_sequencer_bench.sv
module prog_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_class_i = 3'd0;
    logic [2:0] cond_i = 3'd0;
    logic [9:0] target_i = 10'd0;
    logic       sel_i = 1'b0, zero_i = 1'b0, carry_i = 1'b0, irq_i = 1'b0;
    logic [9:0] pc_o;
    logic       int_ack_o, int_en_o, restore_o, restore_zero_o, restore_carry_o, stack_ovf_o;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string req_q[$];

    int exp_pc = 0;
    bit exp_ie = 0;
    int mst [31];
    int mptr = 0, mfill = 0;
    bit movf = 0, sav_z = 0, sav_c = 0;

    always #4 clk = ~clk;

    prog_sequencer u_prog_sequencer (
        .clk(clk), .rst(rst), .op_class_i(op_class_i), .cond_i(cond_i),
        .target_i(target_i), .sel_i(sel_i), .zero_i(zero_i), .carry_i(carry_i),
        .irq_i(irq_i), .pc_o(pc_o), .int_ack_o(int_ack_o), .int_en_o(int_en_o),
        .restore_o(restore_o), .restore_zero_o(restore_zero_o),
        .restore_carry_o(restore_carry_o), .stack_ovf_o(stack_ovf_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            int e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(pc_o == 10'(e), r, int'(pc_o), e);
        end
    end

    function automatic void mpush(input int v);
        mst[mptr] = v;
        mptr = (mptr + 1) % 31;
        if (mfill == 31) movf = 1; else mfill++;
    endfunction

    function automatic int mpop();
        mptr = (mptr + 30) % 31;
        if (mfill > 0) mfill--;
        return mst[mptr];
    endfunction

    function automatic bit cond_ok(input logic [2:0] c);
        if (!c[2]) return 1;
        case (c[1:0])
            2'b00: return zero_i;
            2'b01: return !zero_i;
            2'b10: return carry_i;
            default: return !carry_i;
        endcase
    endfunction

    task automatic run(input logic [2:0] op, input logic [2:0] cnd, input logic [9:0] tgt,
                       input logic s, input string req);
        bit pass;
        int nxt;
        op_class_i = op; cond_i = cnd; target_i = tgt; sel_i = s;
        pass = cond_ok(cnd);
        @(posedge clk); #1;
        chk(pc_o == 10'(exp_pc), "R1 pc held in first clock", int'(pc_o), exp_pc);
        chk(restore_o == (op == 3'd4), "R4/R7 restore strobe", int'(restore_o), int'(op == 3'd4));
        if (op == 3'd4) begin
            chk(restore_zero_o == sav_z, "R7 restored zero", int'(restore_zero_o), int'(sav_z));
            chk(restore_carry_o == sav_c, "R7 restored carry", int'(restore_carry_o), int'(sav_c));
        end
        nxt = (exp_pc + 1) % 1024;
        case (op)
            3'd1: if (pass) nxt = tgt;
            3'd2: if (pass) begin mpush(exp_pc); nxt = tgt; end
            3'd3: if (pass) nxt = (mpop() + 1) % 1024;
            3'd4: begin nxt = mpop(); exp_ie = s; end
            3'd5: exp_ie = s;
            default: ;
        endcase
        @(posedge clk); #1;
        exp_pc = nxt;
        exp_q.push_back(exp_pc); req_q.push_back(req);
        chk(int_en_o == exp_ie, "R8/R7 enable", int'(int_en_o), int'(exp_ie));
        chk(stack_ovf_o == movf, "R5 overflow flag", int'(stack_ovf_o), int'(movf));
        if (exp_ie && irq_i) begin
            mpush(exp_pc);
            exp_ie = 0;
            @(posedge clk); #1;
            chk(int_ack_o == 1'b1, "R6 ack on second event clock", int'(int_ack_o), 1);
            sav_z = zero_i; sav_c = carry_i;
            @(posedge clk); #1;
            exp_pc = 10'h3FF;
            exp_q.push_back(exp_pc); req_q.push_back("R6 vector");
            chk(int_en_o == 1'b0, "R6 enable cleared", int'(int_en_o), 0);
            chk(int_ack_o == 1'b0, "R6 ack single clock", int'(int_ack_o), 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(int_ack_o == 1'b0 && restore_o == 1'b0, "R9 strobes low in reset",
            int'({int_ack_o, restore_o}), 0);
        rst = 1'b0;
        exp_pc = 0; exp_ie = 0; mptr = 0; mfill = 0; movf = 0;
        chk(pc_o == 10'd0, "R9 pc after reset", int'(pc_o), 0);
        chk(int_en_o == 1'b0, "R9 enable after reset", int'(int_en_o), 0);
        chk(stack_ovf_o == 1'b0, "R9 overflow after reset", int'(stack_ovf_o), 0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ret_site;
        do_reset();
        run(3'd0, 3'd0, 10'd0, 1'b0, "R1 seq");
        run(3'd0, 3'd0, 10'd0, 1'b0, "R1 seq");
        run(3'd1, 3'd0, 10'h100, 1'b0, "R3 jump");
        zero_i = 1; carry_i = 0;
        run(3'd1, 3'b100, 10'h120, 1'b0, "R2 zero set taken");
        run(3'd1, 3'b101, 10'h200, 1'b0, "R2 zero clear fails");
        carry_i = 1;
        run(3'd1, 3'b110, 10'h140, 1'b0, "R2 carry set taken");
        run(3'd1, 3'b111, 10'h240, 1'b0, "R2 carry clear fails");
        run(3'd1, 3'b011, 10'h160, 1'b0, "R2 0xx always");
        ret_site = exp_pc;
        run(3'd2, 3'd0, 10'h300, 1'b0, "R3 call");
        run(3'd2, 3'b101, 10'h380, 1'b0, "R2 call fails");
        run(3'd3, 3'b111, 10'h0, 1'b0, "R2 return fails");
        run(3'd3, 3'b110, 10'h0, 1'b0, "R4 return taken");
        chk(exp_pc == ret_site + 1, "R4 model resumes after call", exp_pc, ret_site + 1);
        // R10: request ignored while disabled
        irq_i = 1;
        run(3'd0, 3'd0, 10'd0, 1'b0, "R10 irq ignored");
        run(3'd0, 3'd0, 10'd0, 1'b0, "R10 irq ignored");
        irq_i = 0;
        run(3'd5, 3'd0, 10'd0, 1'b1, "R8 enable");
        run(3'd5, 3'd0, 10'd0, 1'b0, "R8 disable");
        run(3'd5, 3'd0, 10'd0, 1'b1, "R8 enable");
        // R6: interrupt taken after a sequential instruction
        zero_i = 1; carry_i = 0; irq_i = 1;
        ret_site = (exp_pc + 1) % 1024;
        run(3'd0, 3'd0, 10'd0, 1'b0, "R6 preempted pc");
        irq_i = 0; zero_i = 0; carry_i = 1;
        run(3'd0, 3'd0, 10'd0, 1'b0, "R1 wrap to zero");
        run(3'd4, 3'd0, 10'd0, 1'b1, "R7 reti resumes");
        chk(exp_pc == ret_site, "R7 model resume point", exp_pc, ret_site);
        // R6: disable at boundary blocks a pending request
        irq_i = 1;
        run(3'd5, 3'd0, 10'd0, 1'b0, "R6 disable wins");
        run(3'd0, 3'd0, 10'd0, 1'b0, "R10 no vector");
        irq_i = 0;
        // R5: 32 nested calls
        run(3'd1, 3'd0, 10'h010, 1'b0, "R3 jump");
        for (int k = 0; k < 32; k++) begin
            run(3'd2, 3'd0, 10'((exp_pc + 2) % 1024), 1'b0, "R5 nested call");
            if (k == 30) chk(stack_ovf_o == 1'b0, "R5 31 levels fit", int'(stack_ovf_o), 0);
        end
        chk(stack_ovf_o == 1'b1, "R5 32nd push overflows", int'(stack_ovf_o), 1);
        run(3'd3, 3'd0, 10'd0, 1'b0, "R5 newest entry kept");
        run(3'd3, 3'd0, 10'd0, 1'b0, "R5 second newest");
        do_reset();
        run(3'd0, 3'd0, 10'd0, 1'b0, "R9 restart from zero");
        @(negedge clk); @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule